// File: doc/BRIEF.md
# Color Adapter Mode and Palette Registers

This block holds the two programmable registers of a legacy color display adapter: a mode-control byte and a color-select byte. Both are reached over a small CPU-side bus with a chip select, a register select line, separate write and read strobes, and an 8-bit data path. From the mode-control byte the block decodes one of four display modes and a blink enable. From the color-select byte and the current mode it fills a sixteen-entry attribute palette of 4-bit color indices, which a downstream pixel pipeline reads directly from the flattened palette output.

Each graphics mode has its own palette rule. The two-color high-resolution mode places black in entry 0 and the chosen foreground in entry 1. The four-color mode uses the low nibble as the background color and picks one of two fixed color triples, optionally lifted by an intensity base of 8. The composite sixteen-color mode loads the identity palette. Text mode leaves the palette alone. Writing the mode register re-applies the stored color-select byte under the newly chosen mode, so software can change the mode and the palette follows without a second write.

Top module: `chroma_mode_pal`

## Requirements
- R1: After reset the display mode is text (code 0), blink enable is 0, both registers read back 0, and palette entry i holds the value i.
- R2: A mode-control write decodes the mode on `disp_mode`: bit 1 clear gives text (0); bit 1 set with bit 4 clear gives four-color (1); bits 1 and 4 set with bit 3 clear gives two-color high-resolution (2); bits 1, 4 and 3 set gives composite sixteen-color (3).
- R3: Every mode-control write copies its bit 5 to `blink_en`.
- R4: A mode-control write that selects a graphics mode applies the stored color-select byte to the palette under the new mode, exactly as a fresh color-select write would.
- R5: In two-color mode, applying color-select value c sets entry 0 to 0 and entry 1 to c[3:0]; the other entries keep their values.
- R6: In four-color mode, applying c sets entry 0 to c[3:0], and the intensity base b is 8 when c[4] is set, else 0; entries 4 to 15 keep their values.
- R7: In four-color mode, with c[5] set entries 1, 2, 3 become b+3, b+5, b+7; with c[5] clear they become b+2, b+4, b+6.
- R8: In composite mode, applying c sets every entry i to i, whatever c holds.
- R9: In text mode a color-select write only stores the byte and the palette is unchanged; a mode-control write that selects text also leaves the palette unchanged.
- R10: With `cs` and `rd_stb` high, `rdata` returns the mode-control byte when `reg_sel` is 0 and the color-select byte when `reg_sel` is 1, otherwise 0. Writes take effect at the clock edge that samples the strobe, so a read in the same cycle returns the old value.
- R11: A write strobe with `cs` low, or `cs` high without a write strobe, changes no register, mode, blink flag or palette entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select for the register pair |
| reg_sel | input | 1 | 0 selects mode-control, 1 selects color-select |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| disp_mode | output | 2 | Decoded display mode (0 text, 1 four-color, 2 two-color, 3 composite) |
| blink_en | output | 1 | Blink / bright-background enable |
| pal_o | output | 64 | Palette, entry i in bits [4i+3:4i] |

## Verification
The assertions check on every cycle that the blink flag follows the last mode write, that composite mode always shows the identity palette, that two-color and text-mode color writes produce the right entries or no change, and that cycles without a selected write disturb nothing. The four-color rule with its intensity base and alternate triple, the re-application of the stored byte on mode changes, the mode decode across all bit patterns, and the old-value read during a write cycle are shown only by the bench's random and directed scenarios compared against its own palette model.

// File: rtl/chroma_pkg.sv
package chroma_pkg;

   typedef enum logic [1:0] {
      DM_TEXT    = 2'd0,
      DM_QUAD    = 2'd1,
      DM_MONO_HI = 2'd2,
      DM_COMP    = 2'd3
   } disp_mode_e;

   // mode-control bit positions
   localparam int unsigned MC_GFX   = 1;
   localparam int unsigned MC_COMP  = 3;
   localparam int unsigned MC_HIRES = 4;
   localparam int unsigned MC_BLINK = 5;

   // color-select bit positions
   localparam int unsigned CS_BRIGHT = 4;
   localparam int unsigned CS_ALT    = 5;

   localparam int unsigned BRIGHT_BASE = 8;

endpackage

// File: rtl/chroma_mode_dec.sv
module chroma_mode_dec
   import chroma_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic [DW-1:0] mc,
   output disp_mode_e    mode,
   output logic          blink
);

   always_comb begin
      if (!mc[MC_GFX])
         mode = DM_TEXT;
      else if (!mc[MC_HIRES])
         mode = DM_QUAD;
      else if (mc[MC_COMP])
         mode = DM_COMP;
      else
         mode = DM_MONO_HI;
   end

   assign blink = mc[MC_BLINK];

endmodule

// File: rtl/chroma_pal_rule.sv
module chroma_pal_rule
   import chroma_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter int unsigned PAL_N = 16,
   parameter int unsigned PAL_W = 4
) (
   input  disp_mode_e             mode,
   input  logic [DW-1:0]          csel,
   output logic [PAL_N-1:0]       we,
   output logic [PAL_N*PAL_W-1:0] nxt
);

   logic [PAL_W-1:0] base;
   logic [PAL_W-1:0] fg;
   logic [PAL_W-1:0] tri_off;

   assign base    = csel[CS_BRIGHT] ? PAL_W'(BRIGHT_BASE) : '0;
   assign fg      = PAL_W'(csel[3:0]);
   assign tri_off = csel[CS_ALT] ? PAL_W'(1) : PAL_W'(0);

   for (genvar i = 0; i < PAL_N; i++) begin : g_ent
      always_comb begin
         we[i]                     = 1'b0;
         nxt[i*PAL_W +: PAL_W]     = '0;
         unique case (mode)
            DM_MONO_HI: begin
               if (i == 0) begin
                  we[i] = 1'b1;
                  nxt[i*PAL_W +: PAL_W] = '0;
               end else if (i == 1) begin
                  we[i] = 1'b1;
                  nxt[i*PAL_W +: PAL_W] = fg;
               end
            end
            DM_QUAD: begin
               if (i == 0) begin
                  we[i] = 1'b1;
                  nxt[i*PAL_W +: PAL_W] = fg;
               end else if (i < 4) begin
                  we[i] = 1'b1;
                  nxt[i*PAL_W +: PAL_W] = base + PAL_W'(2 * i) + tri_off;
               end
            end
            DM_COMP: begin
               we[i] = 1'b1;
               nxt[i*PAL_W +: PAL_W] = PAL_W'(i);
            end
            default: begin
               we[i] = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/chroma_pal_bank.sv
module chroma_pal_bank #(
   parameter int unsigned PAL_N = 16,
   parameter int unsigned PAL_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [PAL_N-1:0]       we,
   input  logic [PAL_N*PAL_W-1:0] nxt,
   output logic [PAL_N*PAL_W-1:0] q
);

   for (genvar i = 0; i < PAL_N; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i*PAL_W +: PAL_W] <= PAL_W'(i);
         else if (we[i])
            q[i*PAL_W +: PAL_W] <= nxt[i*PAL_W +: PAL_W];
      end
   end

endmodule

// File: rtl/chroma_mode_pal.sv
module chroma_mode_pal
   import chroma_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter int unsigned PAL_N = 16,
   parameter int unsigned PAL_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs,
   input  logic                   reg_sel,
   input  logic                   wr_stb,
   input  logic                   rd_stb,
   input  logic [DW-1:0]          wdata,
   output logic [DW-1:0]          rdata,
   output logic [1:0]             disp_mode,
   output logic                   blink_en,
   output logic [PAL_N*PAL_W-1:0] pal_o
);

   localparam int unsigned PAL_BITS = PAL_N * PAL_W;

   if (DW < 6) begin : g_chk_dw
      $error("chroma_mode_pal: DW must be at least 6");
   end
   if (PAL_W < 4) begin : g_chk_w
      $error("chroma_mode_pal: PAL_W must be at least 4");
   end
   if (PAL_N < 4 || PAL_N > (1 << PAL_W)) begin : g_chk_n
      $error("chroma_mode_pal: PAL_N must be in 4 .. 2**PAL_W");
   end

   logic [DW-1:0]       mc_q;
   logic [DW-1:0]       cs_q;
   disp_mode_e          mode_q;
   logic                blink_q;

   logic                wr_mc;
   logic                wr_cs;
   disp_mode_e          mode_new;
   logic                blink_new;
   disp_mode_e          rule_mode;
   logic [DW-1:0]       rule_cs;
   logic [PAL_N-1:0]    rule_we;
   logic [PAL_N-1:0]    bank_we;
   logic [PAL_BITS-1:0] rule_nxt;

   assign wr_mc = cs && wr_stb && !reg_sel;
   assign wr_cs = cs && wr_stb &&  reg_sel;

   chroma_mode_dec #(.DW(DW)) u_dec (
      .mc    (wdata),
      .mode  (mode_new),
      .blink (blink_new)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mc_q    <= '0;
         cs_q    <= '0;
         mode_q  <= DM_TEXT;
         blink_q <= 1'b0;
      end else begin
         if (wr_mc) begin
            mc_q    <= wdata;
            mode_q  <= mode_new;
            blink_q <= blink_new;
         end
         if (wr_cs)
            cs_q <= wdata;
      end
   end

   // a mode write re-applies the stored color byte under the new mode
   assign rule_mode = wr_mc ? mode_new : mode_q;
   assign rule_cs   = wr_cs ? wdata    : cs_q;

   chroma_pal_rule #(.DW(DW), .PAL_N(PAL_N), .PAL_W(PAL_W)) u_rule (
      .mode (rule_mode),
      .csel (rule_cs),
      .we   (rule_we),
      .nxt  (rule_nxt)
   );

   assign bank_we = rule_we & {PAL_N{wr_mc || wr_cs}};

   chroma_pal_bank #(.PAL_N(PAL_N), .PAL_W(PAL_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we),
      .nxt   (rule_nxt),
      .q     (pal_o)
   );

   assign rdata     = (cs && rd_stb) ? (reg_sel ? cs_q : mc_q) : '0;
   assign disp_mode = mode_q;
   assign blink_en  = blink_q;

endmodule

// File: rtl/chroma_mode_pal_chk.sv
module chroma_mode_pal_chk #(
   parameter int unsigned DW    = 8,
   parameter int unsigned PAL_N = 16,
   parameter int unsigned PAL_W = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cs,
   input logic                   reg_sel,
   input logic                   wr_stb,
   input logic [DW-1:0]          wdata,
   input logic [1:0]             disp_mode,
   input logic                   blink_en,
   input logic [PAL_N*PAL_W-1:0] pal_o
);

   logic [PAL_N*PAL_W-1:0] ident;
   always_comb begin
      for (int i = 0; i < PAL_N; i++)
         ident[i*PAL_W +: PAL_W] = PAL_W'(i);
   end

   // R3: blink follows bit 5 of the last mode write
   a_r3_blink_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr_stb && !reg_sel) |=> (blink_en == $past(wdata[5])));

   // R5: two-color color write
   a_r5_two_color: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr_stb && reg_sel && disp_mode == 2'd2) |=>
      (pal_o[PAL_W-1:0] == '0 && pal_o[2*PAL_W-1:PAL_W] == PAL_W'($past(wdata[3:0]))));

   // R8: composite mode always shows the identity palette
   a_r8_comp_identity: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_mode == 2'd3) |-> (pal_o == ident));

   // R9: text-mode color write keeps the palette
   a_r9_text_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr_stb && reg_sel && disp_mode == 2'd0) |=> $stable(pal_o));

   // R11: no selected write, no change
   a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && wr_stb) |=> ($stable(pal_o) && $stable(disp_mode) && $stable(blink_en)));

endmodule

bind chroma_mode_pal chroma_mode_pal_chk #(.DW(DW), .PAL_N(PAL_N), .PAL_W(PAL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs        (cs),
   .reg_sel   (reg_sel),
   .wr_stb    (wr_stb),
   .wdata     (wdata),
   .disp_mode (disp_mode),
   .blink_en  (blink_en),
   .pal_o     (pal_o)
);

// File: tb/sim_chroma_mode_pal.sv
`timescale 1ns/1ps
module sim_chroma_mode_pal;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0;
   logic        reg_sel = 1'b0;
   logic        wr_stb = 1'b0;
   logic        rd_stb = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [1:0]  disp_mode;
   logic        blink_en;
   logic [63:0] pal_o;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   chroma_mode_pal u0 (
      .clk(clk), .rst_n(rst_n), .cs(cs), .reg_sel(reg_sel),
      .wr_stb(wr_stb), .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata),
      .disp_mode(disp_mode), .blink_en(blink_en), .pal_o(pal_o)
   );

   // reference model
   logic [7:0] m_mc, m_cs;
   logic [1:0] m_mode;
   logic       m_blink;
   logic [3:0] m_pal [16];

   function automatic logic [1:0] exp_mode(logic [7:0] m);
      if (!m[1])      return 2'd0;
      else if (!m[4]) return 2'd1;
      else if (m[3])  return 2'd3;
      else            return 2'd2;
   endfunction

   function automatic logic [63:0] flat_pal();
      logic [63:0] f;
      for (int i = 0; i < 16; i++) f[i*4 +: 4] = m_pal[i];
      return f;
   endfunction

   task automatic apply_rule(logic [1:0] md, logic [7:0] c);
      logic [3:0] b;
      b = c[4] ? 4'd8 : 4'd0;
      case (md)
         2'd2: begin m_pal[0] = 4'd0; m_pal[1] = c[3:0]; end
         2'd1: begin
            m_pal[0] = c[3:0];
            if (c[5]) begin m_pal[1] = b + 4'd3; m_pal[2] = b + 4'd5; m_pal[3] = b + 4'd7; end
            else      begin m_pal[1] = b + 4'd2; m_pal[2] = b + 4'd4; m_pal[3] = b + 4'd6; end
         end
         2'd3: for (int i = 0; i < 16; i++) m_pal[i] = 4'(i);
         default: ;
      endcase
   endtask

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_state(string tag);
      chk({tag, " mode"},    64'(disp_mode), 64'(m_mode));
      chk({tag, " blink"},   64'(blink_en),  64'(m_blink));
      chk({tag, " palette"}, pal_o,          flat_pal());
   endtask

   // write; en_cs/en_wr allow stray strobes (R11)
   task automatic do_wr(bit sel, logic [7:0] d, bit en_cs, bit en_wr, string tag);
      @(negedge clk);
      cs = en_cs; reg_sel = sel; wr_stb = en_wr; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr_stb = 1'b0;
      if (en_cs && en_wr) begin
         if (!sel) begin
            m_mc = d; m_mode = exp_mode(d); m_blink = d[5];
            apply_rule(m_mode, m_cs);
         end else begin
            m_cs = d;
            apply_rule(m_mode, d);
         end
      end
      chk_state(tag);
   endtask

   task automatic do_rd(bit sel, string tag);
      @(negedge clk);
      cs = 1'b1; reg_sel = sel; rd_stb = 1'b1;
      #1;
      chk(tag, 64'(rdata), 64'(sel ? m_cs : m_mc));
      @(negedge clk);
      cs = 1'b0; rd_stb = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : main
      m_mc = '0; m_cs = '0; m_mode = 2'd0; m_blink = 1'b0;
      for (int i = 0; i < 16; i++) m_pal[i] = 4'(i);
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_state("R1 reset");
      do_rd(1'b0, "R1 reset mode readback");
      do_rd(1'b1, "R1 reset color readback");
      chk("R10 idle rdata zero", 64'(rdata), 64'd0);

      // R9 text: color write stores only
      do_wr(1'b1, 8'h3A, 1'b1, 1'b1, "R9 text color write");
      do_rd(1'b1, "R9 R10 color readback");
      // R4 mode change to four-color re-applies 0x3A (bright, alt set)
      do_wr(1'b0, 8'h22, 1'b1, 1'b1, "R4 R6 R7 R3 quad via mode write");
      do_wr(1'b1, 8'h05, 1'b1, 1'b1, "R6 R7 quad plain set");
      do_wr(1'b1, 8'h1C, 1'b1, 1'b1, "R6 quad bright base");
      do_wr(1'b1, 8'h2F, 1'b1, 1'b1, "R7 quad alt no base");
      // R5 two-color
      do_wr(1'b0, 8'h12, 1'b1, 1'b1, "R2 R4 R5 two-color mode");
      do_wr(1'b1, 8'h09, 1'b1, 1'b1, "R5 two-color fg");
      // R8 composite
      do_wr(1'b0, 8'h1A, 1'b1, 1'b1, "R2 R8 composite mode");
      do_wr(1'b1, 8'hFF, 1'b1, 1'b1, "R8 composite color write");
      // R9 back to text keeps palette
      do_wr(1'b0, 8'h20, 1'b1, 1'b1, "R9 R3 text mode keeps palette");
      do_wr(1'b1, 8'h11, 1'b1, 1'b1, "R9 text color write again");
      do_wr(1'b0, 8'h02, 1'b1, 1'b1, "R4 quad reapply after text");
      // R11 stray strobes
      do_wr(1'b1, 8'h0E, 1'b0, 1'b1, "R11 write without cs");
      do_wr(1'b0, 8'h3A, 1'b1, 1'b0, "R11 cs without write");
      do_rd(1'b1, "R11 color unchanged");
      do_rd(1'b0, "R11 mode unchanged");

      // R10 read during the write cycle returns old value
      @(negedge clk);
      cs = 1'b1; reg_sel = 1'b1; wr_stb = 1'b1; rd_stb = 1'b1; wdata = 8'hA7;
      #1;
      chk("R10 same-cycle read old", 64'(rdata), 64'(m_cs));
      @(negedge clk);
      wr_stb = 1'b0;
      m_cs = 8'hA7; apply_rule(m_mode, m_cs);
      #1;
      chk("R10 read after write new", 64'(rdata), 64'hA7);
      chk_state("R10 state after write");
      @(negedge clk);
      cs = 1'b0; rd_stb = 1'b0;

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [7:0] d;
         logic [3:0] k;
         d = 8'($urandom);
         k = 4'($urandom);
         if (k < 4'd5)       do_wr(1'b0, d, 1'b1, 1'b1, "R2 R3 R4 random mode");
         else if (k < 4'd12) do_wr(1'b1, d, 1'b1, 1'b1, "R5 R6 R7 R8 R9 random color");
         else if (k < 4'd13) do_wr(k[0], d, 1'b0, 1'b1, "R11 random stray");
         else                do_rd(k[0], "R10 random readback");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule